// File: doc/BRIEF.md
# Endpoint Interrupt Flag Register

This block collects the interrupt conditions of one USB device endpoint. The packet engine reports events as one-cycle pulses: a NAK returned to a host IN token, a NAK returned to a host OUT token, an isochronous underflow, a valid SETUP packet, OUT data that has landed in the current bank, and the two end-of-microframe events of a high-bandwidth isochronous IN endpoint (bank flush and CPU underrun). Each event latches into a sticky flag. Software reads the flags and acknowledges them by writing ones to a separate clear register. An enable register masks the flags onto a single endpoint interrupt line.

An underflow on an IN endpoint means the host read an empty bank and the engine sent a zero-length packet in its place. An underflow on an OUT endpoint means a packet arrived while the bank was full, and that packet was dropped. Both share one flag position with the SETUP indication. The configured endpoint type selects which event owns that position. On a control endpoint, acknowledging the SETUP flag or the OUT-data flag also hands the current bank back to the engine, through a one-cycle strobe.

The CPU side is a small valid/ready bus that is always ready. It has three word offsets and returns read data one cycle after the request.

Top module: `ep_irq_flags`

## Requirements
- R1: After reset the status flags, the enable mask, the interrupt line, the bank-free strobe and the read-response valid are all zero.
- R2: The flag bit positions are: 0 NAK-on-IN, 1 NAK-on-OUT, 2 shared underflow/SETUP, 3 OUT-data received, 4 high-bandwidth flush, 5 high-bandwidth underrun. An event pulse sets its flag on the next clock edge, and the flag stays set until it is cleared.
- R3: Writing to offset 1 clears every flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R4: When an event and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R5: The interrupt output is high exactly when at least one flag is set together with its enable bit.
- R6: The endpoint type input is 00 control, 01 isochronous, 10 bulk, 11 interrupt. It is sampled every cycle. Flag 2 is set by the SETUP event on a control endpoint and by the underflow event on an isochronous endpoint, and the other of the two events is ignored. On a bulk or interrupt endpoint, flag 2 is held clear.
- R7: On a control endpoint, a clear write that removes a set flag 2 or a set flag 3 raises the bank-free output for exactly one cycle, starting right after the write edge. A clear write raises no strobe on other endpoint types, nor when the cleared flag was not set.
- R8: A read returns rsp_valid and data one cycle later. Offset 0 returns the status flags, offset 2 returns the enable mask, and offsets 1 and 3 read as zero. A write to offset 3 has no effect.
- R9: Writing to offset 2 loads the enable mask from the write data.
- R10: The request-ready output is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ep_type_i | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| ev_nak_in_i | input | 1 | NAK returned to an IN token |
| ev_nak_out_i | input | 1 | NAK returned to an OUT token |
| ev_underflow_i | input | 1 | Isochronous underflow |
| ev_setup_i | input | 1 | Valid SETUP packet in the current bank |
| ev_rx_out_i | input | 1 | OUT packet (data or status stage) in the current bank |
| ev_hb_flush_i | input | 1 | High-bandwidth IN banks flushed at end of microframe |
| ev_hb_underrun_i | input | 1 | High-bandwidth IN banks not filled by the CPU in time |
| req_valid_i | input | 1 | CPU request valid |
| req_ready_o | output | 1 | CPU request ready (constant high) |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 2 | Word offset |
| req_wdata_i | input | 6 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 6 | Read data |
| irq_o | output | 1 | Endpoint interrupt |
| bank_free_o | output | 1 | One-cycle strobe that releases the current bank |

## Verification
A table of vectors applies event combinations, endpoint types and clear masks together, and reads the status back after each step. This shows how the steered flag 2 behaves for each type. It also tells a clear that wins from an event that wins, and it tells a zero clear bit from a one. Single events, all events at once, and collisions of an event with a clear of the same flag separate per-bit set logic from crosstalk between bits. Directed steps then check the bank-free strobe: acknowledging the SETUP flag and the OUT-data flag on a control endpoint must raise it, while an isochronous endpoint or a flag that is already clear must not. Further steps check the enable mask, with only some bits enabled, and the unused offsets.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;

  localparam int NFLAG     = 6;
  localparam int F_NAKIN   = 0;
  localparam int F_NAKOUT  = 1;
  localparam int F_SHARED  = 2;
  localparam int F_RXOUT   = 3;
  localparam int F_HBFLUSH = 4;
  localparam int F_HBUNDER = 5;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_EN   = 2'd2;
endpackage

// File: rtl/ep_flag_cell.sv
module ep_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_clr_i,
  output logic flag_o
);
  logic flag_d, flag_q;

  // priority: forced clear, then event, then acknowledge
  always_comb begin
    flag_d = flag_q;
    if (hold_clr_i)  flag_d = 1'b0;
    else if (set_i)  flag_d = 1'b1;
    else if (clr_i)  flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ep_reg_port.sv
module ep_reg_port
  import ep_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NFLAG-1:0]  req_wdata_i,
  input  logic [NFLAG-1:0]  status_i,
  output logic              req_ready_o,
  output logic [NFLAG-1:0]  clr_o,
  output logic [NFLAG-1:0]  en_o,
  output logic              rsp_valid_o,
  output logic [NFLAG-1:0]  rsp_data_o
);
  logic             wr_go, rd_go;
  logic             en_ce;
  logic [NFLAG-1:0] en_d, en_q;
  logic             rsp_valid_d, rsp_valid_q;
  logic [NFLAG-1:0] rsp_data_d, rsp_data_q;

  assign req_ready_o = 1'b1;
  assign wr_go = req_valid_i &  req_write_i;
  assign rd_go = req_valid_i & ~req_write_i;

  always_comb begin
    clr_o = '0;
    if (wr_go && req_addr_i == OFS_CLR) clr_o = req_wdata_i;
  end

  assign en_ce = wr_go && (req_addr_i == OFS_EN);
  assign en_d  = req_wdata_i;

  always_comb begin
    rsp_valid_d = rd_go;
    rsp_data_d  = '0;
    if (rd_go) begin
      case (req_addr_i)
        OFS_STAT: rsp_data_d = status_i;
        OFS_EN:   rsp_data_d = en_q;
        default:  rsp_data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (en_ce) en_q <= en_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign en_o        = en_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/ep_irq_flags.sv
module ep_irq_flags
  import ep_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ep_type_i,
  input  logic              ev_nak_in_i,
  input  logic              ev_nak_out_i,
  input  logic              ev_underflow_i,
  input  logic              ev_setup_i,
  input  logic              ev_rx_out_i,
  input  logic              ev_hb_flush_i,
  input  logic              ev_hb_underrun_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NFLAG-1:0]  req_wdata_i,
  output logic              rsp_valid_o,
  output logic [NFLAG-1:0]  rsp_data_o,
  output logic              irq_o,
  output logic              bank_free_o
);
  // reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  logic             is_ctrl, is_iso, is_bulkint;
  logic [NFLAG-1:0] set_vec, hold_vec, clr_vec, flag_q, en_q;
  logic             bank_d, bank_q;

  assign is_ctrl    = (ep_type_i == EP_CTRL);
  assign is_iso     = (ep_type_i == EP_ISO);
  assign is_bulkint = (ep_type_i == EP_BULK) || (ep_type_i == EP_INTR);

  always_comb begin
    set_vec            = '0;
    set_vec[F_NAKIN]   = ev_nak_in_i;
    set_vec[F_NAKOUT]  = ev_nak_out_i;
    set_vec[F_SHARED]  = (is_ctrl & ev_setup_i) | (is_iso & ev_underflow_i);
    set_vec[F_RXOUT]   = ev_rx_out_i;
    set_vec[F_HBFLUSH] = ev_hb_flush_i;
    set_vec[F_HBUNDER] = ev_hb_underrun_i;
    hold_vec           = '0;
    hold_vec[F_SHARED] = is_bulkint;
  end

  ep_reg_port u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .status_i    (flag_q),
    .req_ready_o (req_ready_o),
    .clr_o       (clr_vec),
    .en_o        (en_q),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ep_flag_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .set_i      (set_vec[i]),
      .clr_i      (clr_vec[i]),
      .hold_clr_i (hold_vec[i]),
      .flag_o     (flag_q[i])
    );
  end

  // acknowledging a pending SETUP or OUT-data flag releases the bank
  assign bank_d = is_ctrl & ((clr_vec[F_SHARED] & flag_q[F_SHARED]) |
                             (clr_vec[F_RXOUT]  & flag_q[F_RXOUT]));

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) bank_q <= 1'b0;
    else             bank_q <= bank_d;
  end

  assign bank_free_o = bank_q;
  assign irq_o       = |(flag_q & en_q);
endmodule

// File: rtl/ep_irq_flags_chk.sv
module ep_irq_flags_chk
  import ep_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ep_type,
  input logic              ev_nak_in,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [NFLAG-1:0]  clr,
  input logic [NFLAG-1:0]  status,
  input logic [NFLAG-1:0]  en,
  input logic              irq,
  input logic              rsp_valid,
  input logic              bank_free
);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[F_NAKIN] && !clr[F_NAKIN]) |=> status[F_NAKIN]);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nak_in |=> status[F_NAKIN]);

  assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  assert_bulk_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ep_type[1] |=> !status[F_SHARED]);

  assert_bank_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_free |-> $past(ep_type == EP_CTRL && req_valid && req_write && req_addr == OFS_CLR));

  assert_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_rsp_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

bind ep_irq_flags ep_irq_flags_chk u_chk (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .ep_type   (ep_type_i),
  .ev_nak_in (ev_nak_in_i),
  .req_valid (req_valid_i),
  .req_write (req_write_i),
  .req_ready (req_ready_o),
  .req_addr  (req_addr_i),
  .clr       (clr_vec),
  .status    (flag_q),
  .en        (en_q),
  .irq       (irq_o),
  .rsp_valid (rsp_valid_o),
  .bank_free (bank_free_o)
);

// File: tb/ep_irq_flags_test.sv
module ep_irq_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ep_type = 2'b00;
  logic [6:0] ev = '0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [5:0] req_wdata = '0;
  logic       req_ready, rsp_valid, irq, bank_free;
  logic [5:0] rsp_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ep_irq_flags uut (
    .clk_i(clk), .rst_ni(rst_n), .ep_type_i(ep_type),
    .ev_nak_in_i(ev[0]), .ev_nak_out_i(ev[1]), .ev_underflow_i(ev[2]),
    .ev_setup_i(ev[3]), .ev_rx_out_i(ev[4]), .ev_hb_flush_i(ev[5]),
    .ev_hb_underrun_i(ev[6]),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .irq_o(irq), .bank_free_o(bank_free)
  );

  // {events[6:0], type[1:0], clear mask[5:0], expected status[5:0]}
  localparam logic [20:0] VEC [14] = '{
    {7'b0000001, 2'b00, 6'b000000, 6'b000001},
    {7'b0000010, 2'b00, 6'b000000, 6'b000011},
    {7'b0000000, 2'b00, 6'b000000, 6'b000011},
    {7'b0001000, 2'b00, 6'b000001, 6'b000110},
    {7'b0000100, 2'b00, 6'b000100, 6'b000010},
    {7'b0000100, 2'b01, 6'b000000, 6'b000110},
    {7'b0001000, 2'b01, 6'b000100, 6'b000010},
    {7'b0010000, 2'b10, 6'b000000, 6'b001010},
    {7'b1100000, 2'b01, 6'b000010, 6'b111000},
    {7'b0000001, 2'b01, 6'b000001, 6'b111001},
    {7'b0001100, 2'b11, 6'b000000, 6'b111001},
    {7'b0000000, 2'b00, 6'b111111, 6'b000000},
    {7'b1111111, 2'b10, 6'b000000, 6'b111011},
    {7'b0000000, 2'b01, 6'b111011, 6'b000000}
  };

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    tick;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    tick;
    req_valid = 1'b0;
    check("R8 rsp_valid", rsp_valid, 1'b1);
    d = rsp_data;
  endtask

  task automatic pulse(input logic [6:0] e);
    ev = e;
    tick;
    ev = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] d;
    tick; tick;
    rst_n = 1'b1;
    repeat (4) tick;

    // R1 reset state
    check("R1 irq", irq, 1'b0);
    check("R1 bank_free", bank_free, 1'b0);
    check("R1 rsp_valid", rsp_valid, 1'b0);
    check("R10 ready", req_ready, 1'b1);
    rd(2'd0, d); check("R1 status", d, 6'h00);
    rd(2'd2, d); check("R1 enable", d, 6'h00);

    wr(2'd2, 6'h3F);

    // vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 14; i++) begin
      ev        = VEC[i][20:14];
      ep_type   = VEC[i][13:12];
      req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd1;
      req_wdata = VEC[i][11:6];
      tick;
      ev = '0; req_valid = 1'b0; req_write = 1'b0;
      check("R5 irq vs status", irq, |VEC[i][5:0]);
      rd(2'd0, d);
      check("R2/R3/R4/R6 status", d, VEC[i][5:0]);
    end

    // R7 bank release
    ep_type = 2'b00;
    pulse(7'b0001000);
    wr(2'd1, 6'b000100);
    check("R7 setup ack strobe", bank_free, 1'b1);
    tick;
    check("R7 strobe one cycle", bank_free, 1'b0);
    ep_type = 2'b01;
    pulse(7'b0000100);
    wr(2'd1, 6'b000100);
    check("R7 iso ack no strobe", bank_free, 1'b0);
    ep_type = 2'b00;
    wr(2'd1, 6'b001000);
    check("R7 clear of idle flag no strobe", bank_free, 1'b0);
    pulse(7'b0010000);
    wr(2'd1, 6'b001000);
    check("R7 out-data ack strobe", bank_free, 1'b1);
    tick;
    rd(2'd0, d); check("R3 status after acks", d, 6'h00);

    // R5 R9 masking
    wr(2'd2, 6'b000010);
    pulse(7'b0000001);
    check("R5 masked flag no irq", irq, 1'b0);
    pulse(7'b0000010);
    check("R5 enabled flag irq", irq, 1'b1);
    rd(2'd2, d); check("R9 enable readback", d, 6'b000010);

    // R8 unused offsets
    rd(2'd1, d); check("R8 clear offset reads zero", d, 6'h00);
    rd(2'd3, d); check("R8 offset 3 reads zero", d, 6'h00);
    wr(2'd3, 6'h3F);
    rd(2'd2, d); check("R8 offset 3 write ignored", d, 6'b000010);
    rd(2'd0, d); check("R8 status intact", d, 6'b000011);
    tick;
    check("R8 rsp_valid drops", rsp_valid, 1'b0);
    wr(2'd2, 6'h00);
    check("R5 mask cleared no irq", irq, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule